// File: doc/BRIEF.md
# Table Pointer and Latch Unit

This unit moves single bytes between program memory and the data side of a processor. It keeps a 22-bit byte pointer and an 8-bit latch. A table-read command fetches one byte from program memory and places it in the latch. A table-write command hands the latch byte and an address to a write-buffer port. Each command carries one of four pointer-update modes.

Software sees four byte-wide registers through one select field: the low, high and upper bytes of the pointer, and the latch. Pointer bit 21 sits in the upper register and selects the configuration and identification space. The lower 21 bits address up to 2 MB of program space.

Pointer arithmetic never touches bit 21. The memory read port is synchronous and returns data one cycle after the request. While that byte is pending, the unit reports busy.

Top module: `tblptr_unit`

## Requirements
- R1: After reset, all three pointer bytes read as zero, the latch reads as zero, and `busy` is low.
- R2: `reg_addr` selects a register as follows: 0 is pointer low, 1 is pointer high, 2 is pointer upper, and 3 is the latch. The pointer equals upper[5:0]:high:low. The upper register stores only bits 5:0, and its bits 7:6 always read zero.
- R3: A write to `reg_addr`=3 loads the latch. The new value is readable on the next cycle.
- R4: A read command (`cmd_write`=0) accepted in cycle T does two things. It asserts `mem_rd_en` in T, with `mem_rd_addr` set to the full 22-bit access address. It then loads the byte returned in T+1 into the latch at the end of T+1.
- R5: `cmd_mode` encodes the pointer update as follows:
  - 0: the pointer is unchanged and the old pointer is the address.
  - 1: the old pointer is the address and the pointer is incremented.
  - 2: the old pointer is the address and the pointer is decremented.
  - 3: the pointer is incremented and the incremented value is the address.
  The pointer update takes effect at the end of the accepting cycle.
- R6: Increment and decrement change only bits 20:0. Bit 21 keeps its value, and a carry or borrow out of bit 20 is lost.
- R7: A write command (`cmd_write`=1) accepted in cycle T asserts `wb_we` in T. In that cycle `wb_addr` is the access address and `wb_data` is the latch value.
- R8: `busy` is high for exactly the one cycle after an accepted read. A command presented while `busy` is high is ignored: it raises no memory strobe and causes no pointer change.
- R9: If a register write to a pointer byte coincides with a command update, that byte takes the written value. The other bytes take the command's updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value |
| cmd_valid | input | 1 | Table command request |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_mode | input | 2 | Pointer-update mode |
| busy | output | 1 | Read byte pending; commands ignored |
| mem_rd_en | output | 1 | Program-memory read request |
| mem_rd_addr | output | 22 | Program-memory byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after request |
| wb_we | output | 1 | Write-buffer strobe |
| wb_addr | output | 22 | Write-buffer byte address |
| wb_data | output | 8 | Write-buffer data (latch value) |

## Verification
A corrupted pointer shows up in one of two places. It appears on `mem_rd_addr` or `wb_addr` at the next command. It also appears on `reg_rdata` as soon as the affected byte is selected.

A wrong update in bit 21 is the case most likely to escape notice. It shows only near the 21-bit boundary, so the wrap cases are driven there directly.

A stuck or missing pending flag shows in two ways. The latch can hold a stale byte one cycle after a read. Alternatively, `busy` fails to block a command issued in the following cycle.

// File: rtl/tblptr_unit.sv
module tblptr_unit #(
  parameter int PTR_W  = 22,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_mode,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              wb_we,
  output logic [PTR_W-1:0]  wb_addr,
  output logic [BYTE_W-1:0] wb_data
);
  localparam int UP_W  = PTR_W - 2*BYTE_W;
  localparam int LOW_W = PTR_W - 1;

  localparam logic [1:0] SEL_LO = 2'd0;
  localparam logic [1:0] SEL_HI = 2'd1;
  localparam logic [1:0] SEL_UP = 2'd2;
  localparam logic [1:0] SEL_LT = 2'd3;

  localparam logic [1:0] M_NONE = 2'd0;
  localparam logic [1:0] M_PINC = 2'd1;
  localparam logic [1:0] M_PDEC = 2'd2;
  localparam logic [1:0] M_PRE  = 2'd3;

  logic [UP_W-1:0]   up_q;
  logic [BYTE_W-1:0] hi_q, lo_q, latch_q;
  logic              pend_q;
  logic [PTR_W-1:0]  ptr, ptr_inc, ptr_dec, ptr_nxt, acc_addr;
  logic              accept;

  assign ptr     = {up_q, hi_q, lo_q};
  assign ptr_inc = {ptr[PTR_W-1], ptr[LOW_W-1:0] + 1'b1};
  assign ptr_dec = {ptr[PTR_W-1], ptr[LOW_W-1:0] - 1'b1};
  assign accept  = cmd_valid & ~pend_q;
  assign busy    = pend_q;

  always_comb begin
    unique case (cmd_mode)
      M_PINC:  ptr_nxt = ptr_inc;
      M_PDEC:  ptr_nxt = ptr_dec;
      M_PRE:   ptr_nxt = ptr_inc;
      default: ptr_nxt = ptr;
    endcase
  end

  assign acc_addr    = (cmd_mode == M_PRE) ? ptr_inc : ptr;
  assign mem_rd_en   = accept & ~cmd_write;
  assign mem_rd_addr = acc_addr;
  assign wb_we       = accept & cmd_write;
  assign wb_addr     = acc_addr;
  assign wb_data     = latch_q;

  always_comb begin
    unique case (reg_addr)
      SEL_LO:  reg_rdata = lo_q;
      SEL_HI:  reg_rdata = hi_q;
      SEL_UP:  reg_rdata = {{(BYTE_W-UP_W){1'b0}}, up_q};
      default: reg_rdata = latch_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= mem_rd_en;
      if (reg_we && reg_addr == SEL_LO) lo_q <= reg_wdata;
      else if (accept)                  lo_q <= ptr_nxt[BYTE_W-1:0];
      if (reg_we && reg_addr == SEL_HI) hi_q <= reg_wdata;
      else if (accept)                  hi_q <= ptr_nxt[2*BYTE_W-1:BYTE_W];
      if (reg_we && reg_addr == SEL_UP) up_q <= reg_wdata[UP_W-1:0];
      else if (accept)                  up_q <= ptr_nxt[PTR_W-1:2*BYTE_W];
      if (reg_we && reg_addr == SEL_LT) latch_q <= reg_wdata;
      else if (pend_q)                  latch_q <= mem_rd_data;
    end
  end

  assert_bit21_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(reg_we && reg_addr == SEL_UP)) |=> ptr[PTR_W-1] == $past(ptr[PTR_W-1]));

  assert_read_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> busy);

  assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_no_strobe_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!mem_rd_en && !wb_we));

  assert_ptr_held_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !reg_we) |=> ptr == $past(ptr));
endmodule

// File: tb/tblptr_unit_tb.sv
module tblptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        busy;
  logic        mem_rd_en;
  logic [21:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 8'd0;
  logic        wb_we;
  logic [21:0] wb_addr;
  logic [7:0]  wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tblptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_mode(cmd_mode), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5C;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    wr_reg(2'd0, p[7:0]);
    wr_reg(2'd1, p[15:8]);
    wr_reg(2'd2, {2'b00, p[21:16]});
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic get_ptr(output logic [21:0] p);
    logic [7:0] l, h, u;
    rd_reg(2'd0, l); rd_reg(2'd1, h); rd_reg(2'd2, u);
    p = {u[5:0], h, l};
  endtask

  task automatic run_cmd(input string req, input bit wr, input logic [1:0] mode,
                         input logic [21:0] exp_addr, input logic [21:0] exp_ptr);
    logic [21:0] p;
    logic [7:0]  lt, lt0;
    @(negedge clk);
    rd_reg(2'd3, lt0);
    cmd_valid = 1'b1; cmd_write = wr; cmd_mode = mode;
    #1;
    if (wr) begin
      chk(req, "wb_we", wb_we, 1);
      chk(req, "wb_addr", wb_addr, exp_addr);
      chk(req, "wb_data", wb_data, lt0);
      chk(req, "mem_rd_en on write", mem_rd_en, 0);
    end else begin
      chk(req, "mem_rd_en", mem_rd_en, 1);
      chk(req, "mem_rd_addr", mem_rd_addr, exp_addr);
      chk(req, "wb_we on read", wb_we, 0);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!wr) begin
      #1;
      chk(req, "busy after read", busy, 1);
      @(negedge clk);
      #1;
      chk(req, "busy cleared", busy, 0);
      rd_reg(2'd3, lt);
      chk(req, "latch loaded", lt, memf(exp_addr));
    end
    get_ptr(p);
    chk(req, "pointer after", p, exp_ptr);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_reg(2'd0, d); chk("R1", "low", d, 0);
    rd_reg(2'd1, d); chk("R1", "high", d, 0);
    rd_reg(2'd2, d); chk("R1", "upper", d, 0);
    rd_reg(2'd3, d); chk("R1", "latch", d, 0);
    chk("R1", "busy", busy, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr_reg(2'd0, 8'hA5); wr_reg(2'd1, 8'h3C); wr_reg(2'd2, 8'hFF);
    rd_reg(2'd0, d); chk("R2", "low readback", d, 8'hA5);
    rd_reg(2'd1, d); chk("R2", "high readback", d, 8'h3C);
    rd_reg(2'd2, d); chk("R2", "upper bits 7:6 zero", d, 8'h3F);
    wr_reg(2'd3, 8'h5A);
    rd_reg(2'd3, d); chk("R3", "latch readback", d, 8'h5A);
  endtask

  task automatic t_modes;
    set_ptr(22'h12_3456);
    run_cmd("R4", 0, 2'd0, 22'h12_3456, 22'h12_3456);
    run_cmd("R5", 0, 2'd1, 22'h12_3456, 22'h12_3457);
    run_cmd("R5", 0, 2'd2, 22'h12_3457, 22'h12_3456);
    run_cmd("R5", 0, 2'd3, 22'h12_3457, 22'h12_3457);
  endtask

  task automatic t_wrap;
    set_ptr(22'h1F_FFFF);
    run_cmd("R6", 0, 2'd3, 22'h00_0000, 22'h00_0000);
    set_ptr(22'h3F_FFFF);
    run_cmd("R6", 0, 2'd1, 22'h3F_FFFF, 22'h20_0000);
    run_cmd("R6", 0, 2'd2, 22'h20_0000, 22'h3F_FFFF);
  endtask

  task automatic t_write;
    wr_reg(2'd3, 8'h77);
    set_ptr(22'h2A_BC0F);
    run_cmd("R7", 1, 2'd1, 22'h2A_BC0F, 22'h2A_BC10);
    run_cmd("R7", 1, 2'd3, 22'h2A_BC11, 22'h2A_BC11);
  endtask

  task automatic t_busy;
    logic [21:0] p;
    set_ptr(22'h00_1000);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_mode = 2'd1;
    @(negedge clk);
    cmd_write = 1'b1; cmd_mode = 2'd1;
    #1;
    chk("R8", "busy", busy, 1);
    chk("R8", "no wb_we while busy", wb_we, 0);
    chk("R8", "no mem_rd_en while busy", mem_rd_en, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    get_ptr(p);
    chk("R8", "pointer not moved by ignored cmd", p, 22'h00_1001);
  endtask

  task automatic t_collide;
    logic [21:0] p;
    set_ptr(22'h00_00FF);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_mode = 2'd1;
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h10;
    @(negedge clk);
    cmd_valid = 1'b0; reg_we = 1'b0;
    get_ptr(p);
    chk("R9", "register write wins on low byte", p, 22'h00_0110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_modes();
    t_wrap();
    t_write();
    t_busy();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule